// File: doc/BRIEF.md
# I2C dual-DAC register interface

This block is the digital front end of a two-channel 12-bit DAC that is controlled over a 2-wire serial bus. It oversamples the bus clock and data lines with the system clock and finds start and stop conditions. It acknowledges its own 7-bit address, and decodes a channel-select pointer followed by 16-bit control/data words. Each channel has a staged input register and a live DAC register. Control bits in each word can clear everything or move both staged values into the DAC registers together.

A write names the channels in the pointer byte and then sends the word. A read can follow the pointer after a repeated start, or it can be an address-only read that reuses the pointer stored earlier. The DAC registers and the power-down bits drive the analog side, which lies outside this block.

Top module: `i2c_dac2_regif`

## Requirements
- R1: The slave answers only the address {6'b000110, a0_i} and acknowledges it by asserting sda_oe_o for the ninth clock. For any other address, sda_oe_o stays low and no register changes until the next start.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. After a stop, sda_oe_o is low.
- R3: In the pointer byte (the byte after a write address), bit 0 selects channel A and bit 1 selects channel B. With both bits set, the same word goes to both channels. With neither set, no input register is written.
- R4: The word arrives as two bytes, MSB first, and every byte is acknowledged. Bits 15:14 go to pwrdn_o, bit 13 is the clear control, bit 12 is the load control, and bits 11:0 are channel data.
- R5: A completed word with bit 13 = 0 zeroes all input registers and both DAC registers.
- R6: A completed word with bit 13 = 1 and bit 12 = 0 copies both input registers into both DAC registers in the same cycle. With bit 12 = 1, the DAC registers do not change.
- R7: A read after a repeated start returns, high byte first, {pwrdn, 1'b1, 1'b0, input register} of the selected channel. Channel A is returned when both select bits are set.
- R8: An address-only read uses the stored pointer. After reset the pointer is 2'b00, and a read then returns 16'h2000.
- R9: After the master does not acknowledge a read byte, the slave keeps SDA released until the next start.
- R10: A stop or a start that arrives before the second byte of a word is complete discards that word, and no register changes.
- R11: During and after reset, sda_oe_o, both DAC outputs and pwrdn_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| a0_i | input | 1 | Strap that sets the address LSB |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain) |
| dac_a_o | output | DATA_W | Channel A DAC register |
| dac_b_o | output | DATA_W | Channel B DAC register |
| pwrdn_o | output | 2 | Power-down bits from the last word |

## Verification
The bench builds the block with DATA_W = 12, two synchronizer stages and the default address prefix. This keeps every word bit meaningful and lets the bench model the full register state exactly. With that configuration the bench can sweep all 128 addresses for both strap values, and every pointer value against both settings of the load control. Each write is followed by a readback, and the bench also exercises the clear control, aborted words, and reads that end with a NACK.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    localparam int NCH      = 2;
    localparam int WORD_W   = 16;
    localparam int FIELD_W  = 12;
    localparam int CLR_BIT  = 13;
    localparam int LOAD_BIT = 12;
    localparam logic [WORD_W-1:0] RB_EMPTY = 16'h2000;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK,
        S_TX,
        S_MACK,
        S_SKIP
    } bus_st_e;

    typedef enum logic [2:0] {
        P_ADDR,
        P_PTR,
        P_DHI,
        P_DLO,
        P_RHI,
        P_RLO
    } phase_e;

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], raw_i};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.chain <= '1;
            s_q.prev  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign lvl_o  = s_q.chain[STAGES-1];
    assign rise_o = s_q.chain[STAGES-1] & ~s_q.prev;
    assign fall_o = ~s_q.chain[STAGES-1] & s_q.prev;

endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
    import dacif_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CH     = NCH
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit_i,
    input  logic [WORD_W-1:0]          word_i,
    input  logic [CH-1:0]              sel_i,
    output logic [CH-1:0][DATA_W-1:0]  inreg_o,
    output logic [CH-1:0][DATA_W-1:0]  dacreg_o,
    output logic [1:0]                 pd_o
);

    localparam int TOP_BIT = FIELD_W - 1;

    typedef struct packed {
        logic [CH-1:0][DATA_W-1:0] inr;
        logic [CH-1:0][DATA_W-1:0] dac;
        logic [1:0]                pd;
    } bank_t;

    bank_t r_d, r_q;
    logic [DATA_W-1:0] field;

    assign field = word_i[TOP_BIT -: DATA_W];

    always_comb begin
        r_d = r_q;
        if (commit_i) begin
            r_d.pd = word_i[WORD_W-1 -: 2];
            if (!word_i[CLR_BIT]) begin
                r_d.inr = '0;
                r_d.dac = '0;
            end else begin
                for (int ch = 0; ch < CH; ch++) begin
                    if (sel_i[ch]) begin
                        r_d.inr[ch] = field;
                    end
                end
                if (!word_i[LOAD_BIT]) begin
                    r_d.dac = r_d.inr;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign inreg_o  = r_q.inr;
    assign dacreg_o = r_q.dac;
    assign pd_o     = r_q.pd;

endmodule

// File: rtl/i2c_dac2_regif.sv
module i2c_dac2_regif
    import dacif_pkg::*;
#(
    parameter int         DATA_W  = 12,
    parameter int         STAGES  = 2,
    parameter logic [5:0] ADDR_HI = 6'b000110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a0_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [DATA_W-1:0] dac_a_o,
    output logic [DATA_W-1:0] dac_b_o,
    output logic [1:0]        pwrdn_o
);

    localparam int TOP_BIT = FIELD_W - 1;
    localparam int CNT_W   = 4;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(8);

    typedef struct packed {
        bus_st_e           st;
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [7:0]        sh;
        logic [7:0]        hold;
        logic [7:0]        tx;
        logic [1:0]        ptr;
        logic              nack;
        logic              oe;
        logic              commit;
        logic [WORD_W-1:0] word;
    } ctl_t;

    ctl_t c_d, c_q;

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_ev, stop_ev;

    logic                          commit_w;
    logic [WORD_W-1:0]             word_w;
    logic [NCH-1:0]                ptr_w;
    logic [NCH-1:0][DATA_W-1:0]    inreg_w;
    logic [NCH-1:0][DATA_W-1:0]    dacreg_w;

    logic [FIELD_W-1:0] rb_field;
    logic [WORD_W-1:0]  rb_word;
    logic [7:0]         next_tx;

    dacif_sync #(.STAGES(STAGES)) u_scl_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (scl_i),
        .lvl_o  (scl_lvl),
        .rise_o (scl_rise),
        .fall_o (scl_fall)
    );

    dacif_sync #(.STAGES(STAGES)) u_sda_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (sda_i),
        .lvl_o  (sda_lvl),
        .rise_o (sda_rise),
        .fall_o (sda_fall)
    );

    assign start_ev = sda_fall & scl_lvl;
    assign stop_ev  = sda_rise & scl_lvl;

    // Readback word: selected input register in the word layout, A first.
    always_comb begin
        rb_field = '0;
        if (c_q.ptr[0]) begin
            rb_field[TOP_BIT -: DATA_W] = inreg_w[0];
        end else if (c_q.ptr[1]) begin
            rb_field[TOP_BIT -: DATA_W] = inreg_w[1];
        end
        if (c_q.ptr == 2'b00) begin
            rb_word = RB_EMPTY;
        end else begin
            rb_word = {pwrdn_o, 1'b1, 1'b0, rb_field};
        end
    end

    always_comb begin
        c_d        = c_q;
        c_d.commit = 1'b0;
        next_tx    = rb_word[15:8];
        if (start_ev) begin
            c_d.st  = S_RX;
            c_d.ph  = P_ADDR;
            c_d.cnt = '0;
            c_d.oe  = 1'b0;
        end else if (stop_ev) begin
            c_d.st  = S_IDLE;
            c_d.cnt = '0;
            c_d.oe  = 1'b0;
        end else begin
            case (c_q.st)
                S_RX: begin
                    if (scl_rise && c_q.cnt < LAST_BIT) begin
                        c_d.sh  = {c_q.sh[6:0], sda_lvl};
                        c_d.cnt = c_q.cnt + CNT_W'(1);
                    end else if (scl_fall && c_q.cnt == LAST_BIT) begin
                        c_d.cnt = '0;
                        c_d.oe  = 1'b1;
                        c_d.st  = S_ACK;
                        case (c_q.ph)
                            P_ADDR: begin
                                if (c_q.sh[7:1] == {ADDR_HI, a0_i}) begin
                                    c_d.ph = c_q.sh[0] ? P_RHI : P_PTR;
                                end else begin
                                    c_d.oe = 1'b0;
                                    c_d.st = S_SKIP;
                                end
                            end
                            P_PTR: begin
                                c_d.ptr = c_q.sh[1:0];
                                c_d.ph  = P_DHI;
                            end
                            P_DHI: begin
                                c_d.hold = c_q.sh;
                                c_d.ph   = P_DLO;
                            end
                            default: begin
                                c_d.commit = 1'b1;
                                c_d.word   = {c_q.hold, c_q.sh};
                                c_d.ph     = P_DHI;
                            end
                        endcase
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        c_d.cnt = '0;
                        if (c_q.ph == P_RHI) begin
                            c_d.st = S_TX;
                            c_d.tx = rb_word[15:8];
                            c_d.oe = ~rb_word[15];
                        end else begin
                            c_d.st = S_RX;
                            c_d.oe = 1'b0;
                        end
                    end
                end
                S_TX: begin
                    if (scl_rise) begin
                        c_d.cnt = c_q.cnt + CNT_W'(1);
                    end else if (scl_fall) begin
                        if (c_q.cnt == LAST_BIT) begin
                            c_d.oe = 1'b0;
                            c_d.st = S_MACK;
                        end else begin
                            c_d.tx = {c_q.tx[6:0], 1'b0};
                            c_d.oe = ~c_q.tx[6];
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) begin
                        c_d.nack = sda_lvl;
                    end else if (scl_fall) begin
                        if (c_q.nack) begin
                            c_d.st = S_SKIP;
                            c_d.oe = 1'b0;
                        end else begin
                            if (c_q.ph == P_RHI) begin
                                c_d.ph  = P_RLO;
                                next_tx = rb_word[7:0];
                            end else begin
                                c_d.ph  = P_RHI;
                                next_tx = rb_word[15:8];
                            end
                            c_d.tx  = next_tx;
                            c_d.oe  = ~next_tx[7];
                            c_d.cnt = '0;
                            c_d.st  = S_TX;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.st   <= S_IDLE;
            c_q.ph   <= P_ADDR;
        end else begin
            c_q <= c_d;
        end
    end

    assign commit_w = c_q.commit;
    assign word_w   = c_q.word;
    assign ptr_w    = c_q.ptr;
    assign sda_oe_o = c_q.oe;

    dacif_regs #(.DATA_W(DATA_W), .CH(NCH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit_w),
        .word_i   (word_w),
        .sel_i    (ptr_w),
        .inreg_o  (inreg_w),
        .dacreg_o (dacreg_w),
        .pd_o     (pwrdn_o)
    );

    assign dac_a_o = dacreg_w[0];
    assign dac_b_o = dacreg_w[1];

endmodule

// File: rtl/dacif_chk.sv
module dacif_chk
    import dacif_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       commit,
    input logic [WORD_W-1:0]          word,
    input logic [NCH-1:0]             sel,
    input logic [NCH-1:0][DATA_W-1:0] inreg,
    input logic [NCH-1:0][DATA_W-1:0] dacreg,
    input logic [1:0]                 pd,
    input logic                       sda_oe,
    input logic                       stop_ev
);

    localparam int TOP_BIT = FIELD_W - 1;

    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        commit && !word[CLR_BIT] |=> (dacreg == '0) && (inreg == '0)); // R5

    AST_LOAD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        commit && word[CLR_BIT] && !word[LOAD_BIT] |=> dacreg == inreg); // R6

    AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        commit && word[CLR_BIT] && word[LOAD_BIT] |=> $stable(dacreg)); // R6

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(dacreg) && $stable(inreg)); // R10

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe); // R2

    AST_SEL_A_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        commit && word[CLR_BIT] && sel[0] |=> inreg[0] == $past(word[TOP_BIT -: DATA_W])); // R3

    AST_PD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> pd == $past(word[WORD_W-1 -: 2])); // R4

endmodule

bind i2c_dac2_regif dacif_chk #(.DATA_W(DATA_W)) u_dacif_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (commit_w),
    .word    (word_w),
    .sel     (ptr_w),
    .inreg   (inreg_w),
    .dacreg  (dacreg_w),
    .pd      (pwrdn_o),
    .sda_oe  (sda_oe_o),
    .stop_ev (stop_ev)
);

// File: tb/i2c_dac2_regif_test.sv
`timescale 1ns/1ps
module i2c_dac2_regif_test;

    localparam int DW = 12;
    localparam int Q  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a0 = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [DW-1:0] dac_a, dac_b;
    logic [1:0] pd;
    wire sda_bus = sda_m & ~sda_oe;

    int n_tests = 0;
    int n_fail  = 0;

    logic [DW-1:0] m_ina = '0, m_inb = '0, m_da = '0, m_db = '0;
    logic [1:0]    m_pd = '0;
    logic [1:0]    m_ptr = '0;

    always #5 clk = ~clk;

    i2c_dac2_regif #(.DATA_W(DW), .STAGES(2)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .a0_i     (a0),
        .scl_i    (scl),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe),
        .dac_a_o  (dac_a),
        .dac_b_o  (dac_b),
        .pwrdn_o  (pd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; wq(); scl = 1'b1; wq();
        ack = ~sda_bus;
        wq(); scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl = 1'b1; wq(); b[i] = sda_bus; wq(); scl = 1'b0;
        end
        wq();
        sda_m = nack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    function automatic logic [6:0] my_addr();
        return {6'b000110, a0};
    endfunction

    function automatic logic [15:0] exp_rb(input logic [1:0] p);
        if (p[0]) return {m_pd, 2'b10, m_ina};
        if (p[1]) return {m_pd, 2'b10, m_inb};
        return 16'h2000;
    endfunction

    task automatic model_write(input logic [1:0] p, input logic [15:0] w);
        m_pd = w[15:14];
        if (!w[13]) begin
            m_ina = '0; m_inb = '0; m_da = '0; m_db = '0;
        end else begin
            if (p[0]) m_ina = w[11:0];
            if (p[1]) m_inb = w[11:0];
            if (!w[12]) begin m_da = m_ina; m_db = m_inb; end
        end
        m_ptr = p;
    endtask

    task automatic check_outputs(input string req);
        chk(req, 32'(dac_a), 32'(m_da));
        chk(req, 32'(dac_b), 32'(m_db));
        chk(req, 32'(pd), 32'(m_pd));
    endtask

    task automatic write_word(input logic [1:0] p, input logic [15:0] w);
        logic ak;
        bus_start();
        send_byte({my_addr(), 1'b0}, ak); chk("R1 address ack", 32'(ak), 32'd1);
        send_byte({6'b0, p}, ak);          chk("R3 pointer ack", 32'(ak), 32'd1);
        send_byte(w[15:8], ak);            chk("R4 high byte ack", 32'(ak), 32'd1);
        send_byte(w[7:0], ak);             chk("R4 low byte ack", 32'(ak), 32'd1);
        bus_stop();
        chk("R2 released after stop", 32'(sda_oe), 32'd0);
        model_write(p, w);
    endtask

    task automatic read_ptr(input logic [1:0] p, output logic [15:0] v);
        logic ak;
        bus_start();
        send_byte({my_addr(), 1'b0}, ak); chk("R7 address ack", 32'(ak), 32'd1);
        send_byte({6'b0, p}, ak);          chk("R7 pointer ack", 32'(ak), 32'd1);
        bus_start();
        send_byte({my_addr(), 1'b1}, ak); chk("R7 read address ack", 32'(ak), 32'd1);
        recv_byte(1'b0, v[15:8]);
        recv_byte(1'b1, v[7:0]);
        bus_stop();
        m_ptr = p;
    endtask

    task automatic read_cur(output logic [15:0] v);
        logic ak;
        bus_start();
        send_byte({my_addr(), 1'b1}, ak); chk("R8 read address ack", 32'(ak), 32'd1);
        recv_byte(1'b0, v[15:8]);
        recv_byte(1'b1, v[7:0]);
        bus_stop();
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic ak, seen;
        logic [15:0] v, w;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 oe in reset", 32'(sda_oe), 32'd0);
        chk("R11 dac a in reset", 32'(dac_a), 32'd0);
        chk("R11 dac b in reset", 32'(dac_b), 32'd0);
        chk("R11 pd in reset", 32'(pd), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R8: default readback with pointer 00
        read_cur(v);
        chk("R8 default readback", 32'(v), 32'h2000);

        // R1: address sweep over both strap values
        for (int s = 0; s < 2; s++) begin
            a0 = s[0];
            for (int ad = 0; ad < 128; ad++) begin
                bus_start();
                send_byte({ad[6:0], 1'b0}, ak);
                chk("R1 address sweep", 32'(ak), 32'(ad[6:0] == my_addr()));
                bus_stop();
                chk("R2 oe after stop", 32'(sda_oe), 32'd0);
            end
        end
        a0 = 1'b1;

        // R1: foreign address followed by a full write is ignored
        bus_start();
        send_byte({7'h2D, 1'b0}, ak);
        send_byte(8'h03, ak); chk("R1 foreign pointer not acked", 32'(ak), 32'd0);
        send_byte(8'h2A, ak); chk("R1 foreign data not acked", 32'(ak), 32'd0);
        send_byte(8'hBC, ak);
        bus_stop();
        check_outputs("R1 foreign write ignored");

        // R3 R4 R6 R7: pointer x load-control sweep
        for (int p = 0; p < 4; p++) begin
            for (int ld = 0; ld < 2; ld++) begin
                w = {p[1:0], 1'b1, ld[0], 12'(12'h35C + p * 12'h111 + ld * 12'h0A5)};
                write_word(p[1:0], w);
                check_outputs("R6 load control sweep");
                read_ptr(p[1:0], v);
                chk("R7 readback sweep", 32'(v), 32'(exp_rb(p[1:0])));
            end
        end

        // R3: both channels with immediate load
        write_word(2'b11, 16'h2ABC);
        check_outputs("R3 both channels");
        chk("R3 dac a value", 32'(dac_a), 32'h0ABC);
        chk("R3 dac b value", 32'(dac_b), 32'h0ABC);

        // R6: stage B only, A untouched, DAC held, then load both
        write_word(2'b10, 16'h3123);
        chk("R6 hold dac b", 32'(dac_b), 32'h0ABC);
        write_word(2'b01, 16'h3456);
        write_word(2'b00, 16'h2000);
        chk("R6 load a", 32'(dac_a), 32'h0456);
        chk("R6 load b", 32'(dac_b), 32'h0123);

        // R8: address-only read reuses last pointer (00 -> empty), then B
        read_cur(v);
        chk("R8 reuse empty pointer", 32'(v), 32'(exp_rb(m_ptr)));
        read_ptr(2'b10, v);
        read_cur(v);
        chk("R8 reuse pointer B", 32'(v), 32'h2123);

        // R10: stop in the middle of the low byte
        bus_start();
        send_byte({my_addr(), 1'b0}, ak);
        send_byte(8'h03, ak);
        send_byte(8'h20, ak);
        send_bits(8'h77, 4);
        bus_stop();
        check_outputs("R10 stop mid byte");
        // R10: start mid byte, then a valid write
        bus_start();
        send_byte({my_addr(), 1'b0}, ak);
        send_byte(8'h01, ak);
        send_bits(8'h2F, 5);
        bus_start();
        send_byte({my_addr(), 1'b0}, ak); chk("R10 resync after start", 32'(ak), 32'd1);
        send_byte(8'h01, ak);
        send_byte(8'h6F, ak);
        send_byte(8'hED, ak);
        bus_stop();
        model_write(2'b01, 16'h6FED);
        check_outputs("R10 write after abort");

        // R9: NACK then extra clocks, SDA stays released
        bus_start();
        send_byte({my_addr(), 1'b1}, ak);
        recv_byte(1'b1, v[15:8]);
        seen = 1'b0;
        for (int k = 0; k < 9; k++) begin
            wq(); seen |= sda_oe; scl = 1'b1; wq(); seen |= sda_oe; wq(); scl = 1'b0; wq(); seen |= sda_oe;
        end
        chk("R9 released after nack", 32'(seen), 32'd0);
        bus_stop();

        // R5: clear control zeroes everything
        write_word(2'b11, 16'h1000);
        check_outputs("R5 clear");
        read_ptr(2'b01, v);
        chk("R5 input a cleared", 32'(v), 32'h2000);
        chk("R5 dac a zero", 32'(dac_a), 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule